// File: doc/BRIEF.md
# Four-Host Shared Device Bus Arbiter

This block lets four requesting hosts take turns on a single device bus. Each host presents a CPU-select flag, an address, read and write strobes, byte enables and write data. It receives read data and an acknowledge in return. A host requests the bus by raising its read or write strobe, and it keeps that strobe high until it is acknowledged.

When the bus is free, the arbiter grants it to the lowest-numbered requesting host. Host 0 has the highest priority and host 3 the lowest. On the next clock edge the arbiter registers that host's transaction onto the device port. It holds the transaction there, unchanged, until the device acknowledges. The device acknowledge is routed straight back to the winning host as a one-cycle pulse, with the device read data on that host's read-data output in the same cycle. The device port is then cleared to all zeros for exactly one cycle before the next grant appears.

Top module: `busArb`

## Requirements
- R1: While rstN is low, and right after it is released, every device-side output (devCpu, devAddr, devRd, devWr, devBe, devWdata) is zero, and every hostAck bit and every hostRdata bit is zero.
- R2: When several hosts request in the same idle cycle, the lowest host index wins. Index 0 beats 1, 1 beats 2, and 2 beats 3.
- R3: On the clock edge that ends an idle cycle with at least one request, the device port takes the winner's address, byte enables, write data, strobe and CPU-select flag. These values are visible from the next cycle on.
- R4: While a transaction is on the device port and devAck is low, the device outputs do not change. This holds even if other hosts raise requests or change their inputs.
- R5: devRd and devWr are never high together. A host that raises both strobes is forwarded as a write: devWr=1 and devRd=0.
- R6: In a cycle where a transaction is on the device port and devAck is high, hostAck is high only for the granted host. In that same cycle, that host's hostRdata equals devRdata, and all other hostRdata slices are zero.
- R7: After the clock edge that ends an acknowledged cycle, devAddr, devRd, devWr, devBe, devWdata and devCpu are all zero.
- R8: Between two back-to-back transactions, the device port is all zero for exactly one cycle. A request that is pending during the acknowledge appears on the device port two cycles after the acknowledge cycle.
- R9: A devAck that arrives while no transaction is on the device port produces no hostAck.
- R10: Each hostAck pulse lasts exactly one cycle, even if devAck stays high for longer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| hostCpu | input | NUM_HOSTS | CPU-select flag per host |
| hostAddr | input | NUM_HOSTS*ADDR_W | Address per host; host i uses slice [i*ADDR_W +: ADDR_W] |
| hostRd | input | NUM_HOSTS | Read strobe per host |
| hostWr | input | NUM_HOSTS | Write strobe per host |
| hostBe | input | NUM_HOSTS*BE_W | Byte enables per host |
| hostWdata | input | NUM_HOSTS*DATA_W | Write data per host |
| hostRdata | output | NUM_HOSTS*DATA_W | Read data returned to each host |
| hostAck | output | NUM_HOSTS | One-cycle acknowledge per host |
| devCpu | output | 1 | CPU-select flag of the current transaction |
| devAddr | output | ADDR_W | Device address |
| devRd | output | 1 | Device read strobe |
| devWr | output | 1 | Device write strobe |
| devBe | output | BE_W | Device byte enables |
| devWdata | output | DATA_W | Device write data |
| devRdata | input | DATA_W | Device read data |
| devAck | input | 1 | Device acknowledge |

## Verification
Two events can land in the same cycle: the acknowledge that ends the current transaction, and a new request from a host that outranks the hosts still waiting. The bench raises host 0's strobe in the very cycle that it drives devAck for host 1. It then checks three things: only host 1 is acknowledged in that cycle, the device port is zero in the following cycle, and host 0, not a waiting lower-priority host, takes the bus the cycle after that.

// File: rtl/busArbPkg.sv
package busArbPkg;

  // Strobes from the control path to the datapath
  typedef struct packed {
    logic load;      // capture the winner onto the device port
    logic clear;     // zero the device port
    logic ackPulse;  // route the device acknowledge to the granted host
  } arbStrobes_t;

endpackage

// File: rtl/busArbCtrl.sv
module busArbCtrl
  import busArbPkg::*;
#(
  parameter int NUM_HOSTS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_HOSTS-1:0] hostReq,
  input  logic                 devAck,
  output logic [NUM_HOSTS-1:0] winSel,
  output logic [NUM_HOSTS-1:0] grantSel,
  output arbStrobes_t          strb
);

  logic busy;

  // Fixed priority: the lowest index wins
  generate
    for (genvar i = 0; i < NUM_HOSTS; i++) begin : g_pick
      if (i == 0) begin : g_top
        assign winSel[i] = hostReq[i];
      end else begin : g_rest
        assign winSel[i] = hostReq[i] & ~(|hostReq[i-1:0]);
      end
    end
  endgenerate

  always_comb begin
    strb.load     = !busy && (|hostReq);
    strb.ackPulse = busy && devAck;
    strb.clear    = busy && devAck;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      grantSel <= '0;
    end else if (strb.load) begin
      busy     <= 1'b1;
      grantSel <= winSel;
    end else if (strb.clear) begin
      busy     <= 1'b0;
      grantSel <= '0;
    end
  end

  // R2: the picker never selects more than one host
  assert_single_winner_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(winSel));

  // R10: an acknowledge is never routed on two consecutive cycles
  assert_ack_one_cycle_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.ackPulse |=> !strb.ackPulse);

  // R6: a running transaction has exactly one owner
  assert_grant_onehot_R6: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> $countones(grantSel) == 1);

endmodule

// File: rtl/busArbDatapath.sv
module busArbDatapath
  import busArbPkg::*;
#(
  parameter int NUM_HOSTS = 4,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int BE_W      = DATA_W / 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  arbStrobes_t                 strb,
  input  logic [NUM_HOSTS-1:0]        winSel,
  input  logic [NUM_HOSTS-1:0]        grantSel,
  input  logic [NUM_HOSTS-1:0]        hostCpu,
  input  logic [NUM_HOSTS*ADDR_W-1:0] hostAddr,
  input  logic [NUM_HOSTS-1:0]        hostRd,
  input  logic [NUM_HOSTS-1:0]        hostWr,
  input  logic [NUM_HOSTS*BE_W-1:0]   hostBe,
  input  logic [NUM_HOSTS*DATA_W-1:0] hostWdata,
  input  logic [DATA_W-1:0]           devRdata,
  output logic [NUM_HOSTS*DATA_W-1:0] hostRdata,
  output logic [NUM_HOSTS-1:0]        hostAck,
  output logic                        devCpu,
  output logic [ADDR_W-1:0]           devAddr,
  output logic                        devRd,
  output logic                        devWr,
  output logic [BE_W-1:0]             devBe,
  output logic [DATA_W-1:0]           devWdata
);

  logic              selCpu, selRd, selWr;
  logic [ADDR_W-1:0] selAddr;
  logic [BE_W-1:0]   selBe;
  logic [DATA_W-1:0] selWdata;

  // AND-OR mux driven by the one-hot winner
  always_comb begin
    selCpu   = 1'b0;
    selRd    = 1'b0;
    selWr    = 1'b0;
    selAddr  = '0;
    selBe    = '0;
    selWdata = '0;
    for (int i = 0; i < NUM_HOSTS; i++) begin
      selCpu   |= hostCpu[i] & winSel[i];
      selRd    |= hostRd[i] & winSel[i];
      selWr    |= hostWr[i] & winSel[i];
      selAddr  |= hostAddr[i*ADDR_W +: ADDR_W] & {ADDR_W{winSel[i]}};
      selBe    |= hostBe[i*BE_W +: BE_W] & {BE_W{winSel[i]}};
      selWdata |= hostWdata[i*DATA_W +: DATA_W] & {DATA_W{winSel[i]}};
    end
  end

  // Registered device port: loaded on a grant, held while busy, zeroed on an ack
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      devCpu   <= 1'b0;
      devAddr  <= '0;
      devRd    <= 1'b0;
      devWr    <= 1'b0;
      devBe    <= '0;
      devWdata <= '0;
    end else if (strb.load) begin
      devCpu   <= selCpu;
      devAddr  <= selAddr;
      devRd    <= selRd & ~selWr;   // a write wins over a read
      devWr    <= selWr;
      devBe    <= selBe;
      devWdata <= selWdata;
    end else if (strb.clear) begin
      devCpu   <= 1'b0;
      devAddr  <= '0;
      devRd    <= 1'b0;
      devWr    <= 1'b0;
      devBe    <= '0;
      devWdata <= '0;
    end
  end

  // Acknowledge and read-data routing
  generate
    for (genvar i = 0; i < NUM_HOSTS; i++) begin : g_route
      assign hostAck[i] = strb.ackPulse & grantSel[i];
      assign hostRdata[i*DATA_W +: DATA_W] = hostAck[i] ? devRdata : '0;
    end
  endgenerate

  // R5: the two device strobes are never high together
  assert_no_rd_wr_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(devRd && devWr));

  // R7: the device port is zero after an acknowledge
  assert_bus_cleared_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (devAddr == '0 && !devRd && !devWr && devBe == '0
                    && devWdata == '0 && !devCpu));

endmodule

// File: rtl/busArb.sv
module busArb
  import busArbPkg::*;
#(
  parameter int NUM_HOSTS = 4,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int BE_W      = DATA_W / 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_HOSTS-1:0]        hostCpu,
  input  logic [NUM_HOSTS*ADDR_W-1:0] hostAddr,
  input  logic [NUM_HOSTS-1:0]        hostRd,
  input  logic [NUM_HOSTS-1:0]        hostWr,
  input  logic [NUM_HOSTS*BE_W-1:0]   hostBe,
  input  logic [NUM_HOSTS*DATA_W-1:0] hostWdata,
  output logic [NUM_HOSTS*DATA_W-1:0] hostRdata,
  output logic [NUM_HOSTS-1:0]        hostAck,
  output logic                        devCpu,
  output logic [ADDR_W-1:0]           devAddr,
  output logic                        devRd,
  output logic                        devWr,
  output logic [BE_W-1:0]             devBe,
  output logic [DATA_W-1:0]           devWdata,
  input  logic [DATA_W-1:0]           devRdata,
  input  logic                        devAck
);

  arbStrobes_t          strb;
  logic [NUM_HOSTS-1:0] hostReq, winSel, grantSel;

  assign hostReq = hostRd | hostWr;

  busArbCtrl #(.NUM_HOSTS(NUM_HOSTS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .hostReq  (hostReq),
    .devAck   (devAck),
    .winSel   (winSel),
    .grantSel (grantSel),
    .strb     (strb)
  );

  busArbDatapath #(
    .NUM_HOSTS(NUM_HOSTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .winSel    (winSel),
    .grantSel  (grantSel),
    .hostCpu   (hostCpu),
    .hostAddr  (hostAddr),
    .hostRd    (hostRd),
    .hostWr    (hostWr),
    .hostBe    (hostBe),
    .hostWdata (hostWdata),
    .devRdata  (devRdata),
    .hostRdata (hostRdata),
    .hostAck   (hostAck),
    .devCpu    (devCpu),
    .devAddr   (devAddr),
    .devRd     (devRd),
    .devWr     (devWr),
    .devBe     (devBe),
    .devWdata  (devWdata)
  );

  // R4: an unacknowledged transaction stays put on the device port
  assert_bus_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((devRd || devWr) && !devAck) |=> ($stable(devAddr) && $stable(devRd)
      && $stable(devWr) && $stable(devBe) && $stable(devWdata) && $stable(devCpu)));

  // R6: at most one host acknowledge per cycle
  assert_ack_onehot_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hostAck));

  // R9: no host acknowledge while the device port is idle
  assert_no_stray_ack_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!devRd && !devWr) |-> hostAck == '0);

endmodule

// File: tb/busArb_bench.sv
module busArb_bench;
  localparam int NH = 4;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int BW = DW / 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NH-1:0]    hostCpu = '0;
  logic [NH*AW-1:0] hostAddr = '0;
  logic [NH-1:0]    hostRd = '0;
  logic [NH-1:0]    hostWr = '0;
  logic [NH*BW-1:0] hostBe = '0;
  logic [NH*DW-1:0] hostWdata = '0;
  logic [NH*DW-1:0] hostRdata;
  logic [NH-1:0]    hostAck;
  logic             devCpu;
  logic [AW-1:0]    devAddr;
  logic             devRd, devWr;
  logic [BW-1:0]    devBe;
  logic [DW-1:0]    devWdata;
  logic [DW-1:0]    devRdata = '0;
  logic             devAck = 1'b0;

  int nTests = 0;
  int nFail = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  busArb u_busArb (
    .clk(clk), .rstN(rstN), .hostCpu(hostCpu), .hostAddr(hostAddr),
    .hostRd(hostRd), .hostWr(hostWr), .hostBe(hostBe), .hostWdata(hostWdata),
    .hostRdata(hostRdata), .hostAck(hostAck), .devCpu(devCpu), .devAddr(devAddr),
    .devRd(devRd), .devWr(devWr), .devBe(devBe), .devWdata(devWdata),
    .devRdata(devRdata), .devAck(devAck)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic setHost(input int h, input bit rd, input bit wr, input logic [AW-1:0] a,
                         input logic [BW-1:0] be, input logic [DW-1:0] wd);
    hostRd[h] = rd;
    hostWr[h] = wr;
    hostAddr[h*AW +: AW] = a;
    hostBe[h*BW +: BW] = be;
    hostWdata[h*DW +: DW] = wd;
  endtask

  function automatic logic [127:0] busVal();
    return {devCpu, devAddr, devRd, devWr, devBe, devWdata};
  endfunction

  function automatic logic [127:0] expBus(input bit cpu, input logic [AW-1:0] a, input bit rd,
                                          input bit wr, input logic [BW-1:0] be,
                                          input logic [DW-1:0] wd);
    return {cpu, a, rd, wr, be, wd};
  endfunction

  // Acknowledge host h at the current negedge, then release it at the next one
  task automatic ackRelease(input int h, input logic [DW-1:0] rdat, input string tag);
    devAck = 1'b1;
    devRdata = rdat;
    #1;
    chk({tag, " R6 ack"}, hostAck, 4'b1 << h);
    chk({tag, " R6 rdata"}, hostRdata, {{(NH-1)*DW{1'b0}}, rdat} << (h*DW));
    @(negedge clk);
    devAck = 1'b0;
    setHost(h, 0, 0, '0, '0, '0);
    #1;
    chk({tag, " R7 bus zero"}, busVal(), '0);
    chk({tag, " R10 ack low"}, hostAck, '0);
  endtask

  task automatic testReset();
    #1;
    chk("R1 bus in reset", busVal(), '0);
    chk("R1 ack in reset", hostAck, '0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    chk("R1 bus after reset", busVal(), '0);
    chk("R1 rdata after reset", hostRdata, '0);
  endtask

  task automatic testSingleRead();
    hostCpu = 4'b0100;
    setHost(2, 1, 0, 16'h1234, 4'h3, 32'hDEAD0002);
    @(negedge clk);
    #1;
    chk("R3 forwarded read", busVal(), expBus(1, 16'h1234, 1, 0, 4'h3, 32'hDEAD0002));
    ackRelease(2, 32'hCAFEF00D, "single");
  endtask

  task automatic testPriority();
    hostCpu = 4'b0001;
    setHost(1, 1, 0, 16'h0111, 4'h1, 32'h11);
    setHost(2, 0, 1, 16'h0222, 4'h2, 32'h22);
    setHost(3, 1, 0, 16'h0333, 4'h4, 32'h33);
    @(negedge clk);
    #1;
    chk("R2 host1 beats 2,3", busVal(), expBus(0, 16'h0111, 1, 0, 4'h1, 32'h11));
    setHost(2, 0, 1, 16'h0AAA, 4'hF, 32'hAA);  // lower host changes inputs while busy
    @(negedge clk);
    #1;
    chk("R4 hold while busy", busVal(), expBus(0, 16'h0111, 1, 0, 4'h1, 32'h11));
    // host0 raises its request in the same cycle as host1's acknowledge
    setHost(0, 0, 1, 16'h0F00, 4'h8, 32'h00F0);
    ackRelease(1, 32'h5151, "prio");
    @(negedge clk);
    #1;
    chk("R8 R2 host0 after one idle", busVal(), expBus(1, 16'h0F00, 0, 1, 4'h8, 32'h00F0));
    ackRelease(0, 32'h0, "prio0");
    @(negedge clk);
    #1;
    chk("R2 host2 next", busVal(), expBus(0, 16'h0AAA, 0, 1, 4'hF, 32'hAA));
    ackRelease(2, 32'h2222, "prio2");
    @(negedge clk);
    #1;
    chk("R2 host3 last", busVal(), expBus(0, 16'h0333, 1, 0, 4'h4, 32'h33));
    ackRelease(3, 32'h3333, "prio3");
  endtask

  task automatic testBothStrobes();
    hostCpu = 4'b1000;
    setHost(3, 1, 1, 16'hBEEF, 4'hC, 32'h12345678);
    @(negedge clk);
    #1;
    chk("R5 write wins", busVal(), expBus(1, 16'hBEEF, 0, 1, 4'hC, 32'h12345678));
    ackRelease(3, 32'h0, "both");
  endtask

  task automatic testStrayAck();
    @(negedge clk);
    devAck = 1'b1;
    devRdata = 32'hFFFF_FFFF;
    #1;
    chk("R9 stray ack ignored", hostAck, '0);
    chk("R9 rdata stays zero", hostRdata, '0);
    @(negedge clk);
    devAck = 1'b0;
    #1;
    chk("R9 bus still idle", busVal(), '0);
  endtask

  task automatic testLongAck();
    hostCpu = 4'b0010;
    setHost(1, 1, 0, 16'h7777, 4'h5, 32'h0);
    @(negedge clk);
    #1;
    chk("R3 host1 read", busVal(), expBus(1, 16'h7777, 1, 0, 4'h5, 32'h0));
    devAck = 1'b1;
    devRdata = 32'h7;
    #1;
    chk("R10 first ack cycle", hostAck, 4'b0010);
    @(negedge clk);
    setHost(1, 0, 0, '0, '0, '0);
    #1;
    chk("R10 held device ack gives no second pulse", hostAck, '0);
    @(negedge clk);
    devAck = 1'b0;
    #1;
    chk("R7 bus zero after long ack", busVal(), '0);
  endtask

  initial begin
    testReset();
    testSingleRead();
    testPriority();
    testBothStrobes();
    testStrayAck();
    testLongAck();
    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule